// File: doc/BRIEF.md
# Time-of-Flight Prompt/Slow Classifier

This block sorts beam particles into fast and slow by how long each one takes to fly from an upstream counter to a downstream counter. It runs on a 200 MHz clock, so one tick is 5 ns. Each input is a discriminated hit that is sampled on every clock edge, and a hit counts as an event in every cycle it is high.

Every upstream hit goes through two shift-register delay lines of different lengths. At the end of each line a retriggerable stretcher opens a window. The short line feeds a narrow window of 10 ns that opens 65 ns after the hit. The long line feeds a wide window of 90 ns that opens 75 ns after the hit. Each downstream hit opens a 10 ns gate. When the downstream gate overlaps the narrow window, the block emits a one-cycle prompt pulse. When the downstream gate overlaps the wide window, it emits a one-cycle slow pulse. Together the two windows put the boundary between the classes at a fixed flight time.

Because the delay is held in shift registers, several upstream hits can travel down the lines at the same time without disturbing each other.

Top module: `tof_flight_classifier`

## Requirements
- R1: When `rst_i` is high at a clock edge, the delay lines, stretchers and output registers are cleared. Hits present during reset are not captured. After any edge sampled in reset, `prompt_o` and `slow_o` are 0.
- R2: A downstream hit sampled at edge n holds the downstream gate high after edges n and n+1. A new hit restarts the 2-tick count.
- R3: An upstream hit sampled at edge u holds the prompt window high after edges u+13 and u+14, which is 65 ns of delay and a 10 ns width.
- R4: An upstream hit sampled at edge u holds the slow window high after edges u+15 through u+32, which is 75 ns of delay and a 90 ns width.
- R5: Define the prompt overlap as the downstream gate AND the prompt window, taken after edge n. If the overlap is 1 after edge n and was 0 after edge n-1, or if n is the first edge after reset, then `prompt_o` is 1 after edge n+1. In every other case it is 0. The pulse therefore lasts exactly one cycle per rising edge of the overlap.
- R6: `slow_o` follows the same rule as R5, using the downstream gate AND the slow window.
- R7: Upstream hits closer together than the delay keep their own timing. Each one opens its own windows as in R3 and R4.
- R8: When both overlaps rise in the same cycle, both outputs pulse in the same cycle. Neither output takes priority over the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 200 MHz clock |
| rst_i | input | 1 | Synchronous reset, active high |
| up_hit_i | input | 1 | Upstream counter hit, sampled each edge |
| dn_hit_i | input | 1 | Downstream counter hit, sampled each edge |
| prompt_o | output | 1 | One-cycle pulse for a fast-particle coincidence |
| slow_o | output | 1 | One-cycle pulse for a slow-particle coincidence |

## Verification
The prompt and slow flags can rise together only when two upstream hits are in flight at once. An upstream hit 13 ticks before a downstream hit puts that hit inside its narrow window. A second upstream hit 15 ticks before the same downstream hit puts that hit at the start of its wide window. A directed phase builds exactly this pair. The bench's behavioural model then predicts a simultaneous pulse on both outputs, and the number of simultaneous pulses seen on the ports must equal the number predicted, which must not be zero. The single-hit separation sweep and the dense random traffic also compare both flags on every cycle, so a priority scheme that suppresses one flag would show up as a miscompare.

// File: rtl/tof_cls_pkg.sv
package tof_cls_pkg;

  // Round a time in ns to whole clock ticks.
  function automatic int ns_to_ticks(input int t_ns, input int tick_ns);
    return (t_ns + tick_ns / 2) / tick_ns;
  endfunction

  // Width of a down-counter that must hold max_val.
  function automatic int cnt_bits(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // Number of classification paths fed from the upstream hit.
  localparam int NUM_PATHS = 2;
  localparam int PATH_PROMPT = 0;
  localparam int PATH_SLOW = 1;

endpackage

// File: rtl/tof_delay_line.sv
module tof_delay_line #(
  parameter int DEPTH = 13
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic din_i,
  output logic tap_o
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) sr_q <= '0;
        else       sr_q <= din_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) sr_q <= '0;
        else       sr_q <= {sr_q[DEPTH-2:0], din_i};
      end
    end
  endgenerate

  // The tap holds the hit from DEPTH-1 edges ago; the next stage adds one more.
  assign tap_o = sr_q[DEPTH-1];
endmodule

// File: rtl/tof_stretcher.sv
module tof_stretcher
  import tof_cls_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  output logic gate_o
);
  localparam int CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)             cnt_q <= '0;
    else if (trig_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign gate_o = (cnt_q != '0);
endmodule

// File: rtl/tof_rise_pulse.sv
module tof_rise_pulse (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_q <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      level_q <= level_i;
      pulse_o <= level_i & ~level_q;
    end
  end
endmodule

// File: rtl/tof_flight_classifier.sv
module tof_flight_classifier
  import tof_cls_pkg::*;
#(
  parameter int TICK_NS     = 5,
  parameter int DN_GATE_NS  = 10,
  parameter int P_DELAY_NS  = 65,
  parameter int P_GATE_NS   = 10,
  parameter int S_DELAY_NS  = 75,
  parameter int S_GATE_NS   = 90
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic up_hit_i,
  input  logic dn_hit_i,
  output logic prompt_o,
  output logic slow_o
);
  localparam int DN_W  = ns_to_ticks(DN_GATE_NS, TICK_NS);
  localparam int P_DLY = ns_to_ticks(P_DELAY_NS, TICK_NS);
  localparam int P_W   = ns_to_ticks(P_GATE_NS, TICK_NS);
  localparam int S_DLY = ns_to_ticks(S_DELAY_NS, TICK_NS);
  localparam int S_W   = ns_to_ticks(S_GATE_NS, TICK_NS);

  // Named internal events, brought out for the checker.
  logic                 dn_gate;
  logic [NUM_PATHS-1:0] up_tap;
  logic [NUM_PATHS-1:0] up_gate;
  logic [NUM_PATHS-1:0] overlap;
  logic [NUM_PATHS-1:0] flag;

  tof_stretcher #(.WIDTH(DN_W)) u_dn_stretch (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .trig_i(dn_hit_i),
    .gate_o(dn_gate)
  );

  generate
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      localparam int DLY = (p == PATH_PROMPT) ? P_DLY : S_DLY;
      localparam int WID = (p == PATH_PROMPT) ? P_W   : S_W;

      tof_delay_line #(.DEPTH(DLY)) u_dly (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .din_i(up_hit_i),
        .tap_o(up_tap[p])
      );

      tof_stretcher #(.WIDTH(WID)) u_stretch (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .trig_i(up_tap[p]),
        .gate_o(up_gate[p])
      );

      assign overlap[p] = dn_gate & up_gate[p];

      tof_rise_pulse u_pulse (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .level_i(overlap[p]),
        .pulse_o(flag[p])
      );
    end
  endgenerate

  assign prompt_o = flag[PATH_PROMPT];
  assign slow_o   = flag[PATH_SLOW];
endmodule

// File: rtl/tof_flight_checker.sv
module tof_flight_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic       dn_hit_i,
  input logic       dn_gate,
  input logic [1:0] up_tap,
  input logic [1:0] up_gate,
  input logic [1:0] overlap,
  input logic       prompt_o,
  input logic       slow_o
);
  AST_RESET_CLEARS_FLAGS: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!prompt_o && !slow_o)); // R1
  AST_RESET_CLEARS_GATES: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!dn_gate && up_gate == 2'b00)); // R1
  AST_DN_GATE_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
    dn_hit_i |=> dn_gate); // R2
  AST_PROMPT_WINDOW_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
    up_tap[0] |=> up_gate[0]); // R3
  AST_SLOW_WINDOW_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
    up_tap[1] |=> up_gate[1]); // R4
  AST_PROMPT_NEEDS_OVERLAP: assert property (@(posedge clk_i) disable iff (rst_i)
    prompt_o |-> $past(overlap[0])); // R5
  AST_PROMPT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    prompt_o |=> !prompt_o); // R5
  AST_SLOW_NEEDS_OVERLAP: assert property (@(posedge clk_i) disable iff (rst_i)
    slow_o |-> $past(overlap[1])); // R6
  AST_SLOW_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    slow_o |=> !slow_o); // R6
endmodule

bind tof_flight_classifier tof_flight_checker u_checker (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .dn_hit_i(dn_hit_i),
  .dn_gate (dn_gate),
  .up_tap  (up_tap),
  .up_gate (up_gate),
  .overlap (overlap),
  .prompt_o(prompt_o),
  .slow_o  (slow_o)
);

// File: tb/tb_tof_flight_classifier.sv
`timescale 1ns/1ps
module tb_tof_flight_classifier;
  localparam int NMAX = 2048;
  // Timing restated from the requirements, in ticks.
  localparam int DN_W  = 2;
  localparam int P_DLY = 13;
  localparam int P_W   = 2;
  localparam int S_DLY = 15;
  localparam int S_W   = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_hit = 1'b0;
  logic dn_hit = 1'b0;
  logic prompt, slow;

  int vectors = 0;
  int errors = 0;
  int both_exp = 0;
  int both_seen = 0;
  bit up_s[NMAX];
  bit dn_s[NMAX];

  always #2.5 clk = ~clk;

  tof_flight_classifier dut (
    .clk_i(clk), .rst_i(rst), .up_hit_i(up_hit), .dn_hit_i(dn_hit),
    .prompt_o(prompt), .slow_o(slow)
  );

  // Window open after edge n if any hit in edges n-dly-w+1 .. n-dly.
  function automatic bit win(input bit is_up, input int n, input int dly, input int w);
    for (int k = 0; k < w; k++) begin
      int i = n - dly - k;
      if (i >= 0 && i < NMAX && (is_up ? up_s[i] : dn_s[i])) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit ovl(input bit slow_path, input int n);
    if (n < 0) return 1'b0;
    if (slow_path) return win(1'b0, n, 0, DN_W) && win(1'b1, n, S_DLY, S_W);
    return win(1'b0, n, 0, DN_W) && win(1'b1, n, P_DLY, P_W);
  endfunction

  // Flag value after edge n: rising edge of the overlap one edge earlier.
  function automatic bit exp_flag(input bit slow_path, input int n);
    return ovl(slow_path, n - 1) && !ovl(slow_path, n - 2);
  endfunction

  task automatic check_bit(input string tag, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < NMAX; i++) begin
      up_s[i] = 1'b0;
      dn_s[i] = 1'b0;
    end
  endtask

  // Reset with hits driven (R1: they must not be captured), then play the stimulus.
  task automatic run_phase(input int len);
    @(negedge clk);
    rst = 1'b1; up_hit = 1'b1; dn_hit = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R1 prompt in reset", prompt, 1'b0);
    check_bit("R1 slow in reset", slow, 1'b0);
    rst = 1'b0; up_hit = up_s[0]; dn_hit = dn_s[0];
    for (int n = 0; n < len; n++) begin
      bit ep, es;
      @(negedge clk);
      ep = exp_flag(1'b0, n);
      es = exp_flag(1'b1, n);
      check_bit("R5 prompt", prompt, ep);
      check_bit("R6 slow", slow, es);
      if (ep && es) both_exp++;
      if (prompt && slow) both_seen++;
      up_hit = (n + 1 < len) ? up_s[n + 1] : 1'b0;
      dn_hit = (n + 1 < len) ? dn_s[n + 1] : 1'b0;
    end
  endtask

  initial begin
    int len;
    // Phase A: dense random traffic, many upstream hits in flight (R7).
    clear_stim();
    len = 1500;
    for (int i = 0; i < len; i++) begin
      up_s[i] = ($urandom % 4) == 0;
      dn_s[i] = ($urandom % 4) == 0;
    end
    for (int i = len - 10; i < len; i++) begin
      up_s[i] = 1'b1;
      dn_s[i] = 1'b1;
    end
    run_phase(len);

    // Phase B: single-pair separation sweep across both windows (R2, R3, R4).
    clear_stim();
    for (int s = 8; s <= 38; s++) begin
      int b = (s - 8) * 60;
      up_s[b] = 1'b1;
      dn_s[b + s] = 1'b1;
    end
    len = 31 * 60 + 10;
    for (int i = len - 10; i < len; i++) up_s[i] = 1'b1;
    run_phase(len);

    // Phase C: two upstream hits 13 and 15 ticks ahead of one downstream hit,
    // so both overlaps rise in one cycle (R8).
    clear_stim();
    for (int t = 0; t < 20; t++) begin
      int m = 40 + t * 70;
      up_s[m - 15] = 1'b1;
      up_s[m - 13] = 1'b1;
      dn_s[m] = 1'b1;
    end
    len = 40 + 20 * 70;
    run_phase(len);

    // Phase D: sparse random traffic with long downstream trains (R2 retrigger).
    clear_stim();
    len = 1500;
    for (int i = 0; i < len; i++) begin
      up_s[i] = ($urandom % 20) == 0;
      dn_s[i] = ($urandom % 9) == 0;
    end
    run_phase(len);

    // R8: simultaneous pulses seen on the ports match the model and occurred.
    vectors++;
    if (both_seen != both_exp || both_exp == 0) begin
      errors++;
      $display("FAIL R8 coincident pulses actual=%0d expected=%0d", both_seen, both_exp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule